// File: doc/BRIEF.md
# Interrupt Controller Error Status Logic

This block watches the traffic of a local interrupt controller and records delivery and register-access faults in a sticky error status register. Outgoing send requests, incoming (or locally generated) interrupt messages, register accesses and bus failure strobes are all inspected in the same clock. Each detected fault sets a flag in a hidden accumulation latch. Software moves the latch into the visible status register by writing the status offset, and this clears the latch. A one-clock error interrupt pulse marks every flag that goes from clear to set in the latch.

Received interrupts with a legal vector leave through a one-deep valid/ready stage as pending-request set commands. Back-pressure rules: `rx_ready` is high whenever the stage is empty or `pend_ready` is high in the same cycle. A held `pend_valid` keeps its vector stable until `pend_ready` is seen. The send port never stalls (`snd_ready` is tied high) because the block only inspects sends and does not carry them. Illegal vectors (0 to 15) are never forwarded to the pending stage.

Top module: `irq_err_status`

## Requirements
- R1: After reset `status_rd` is 0, and `pend_valid`, `err_irq` and `msr_fault` are low.
- R2: When `feat_bus_en` is high, the strobes `bus_snd_cksum`, `bus_rcv_cksum`, `bus_snd_noacc` and `bus_rcv_noacc` set status bits 0, 1, 2 and 3 in that order. When `feat_bus_en` is low these bits stay 0.
- R3: An accepted send (`snd_valid`) with a vector below 16 sets bit 5. This holds for a command send (`snd_self`=0) in either access mode and for a self send (`snd_self`=1) in model-specific mode (`msr_mode`=1). A self send while `msr_mode`=0 has no effect.
- R4: A send with `snd_lowpri`=1 while `cfg_lowpri_ok`=0 sets bit 4 if `feat_redir_en` is high. When `feat_redir_en` is low, bit 4 stays 0.
- R5: An unsupported lowest-priority send is discarded. It never sets bit 5, whatever its vector and whatever `feat_redir_en` is.
- R6: A received message with a vector below 16 sets bit 6 and is dropped. `pend_valid` is never high with `pend_vector` below 16.
- R7: A received message with a vector of 16 or more, accepted when `rx_valid` and `rx_ready` are both high, appears on `pend_valid`/`pend_vector` in the next cycle. It is held there until `pend_ready` is seen. `rx_ready` equals `!pend_valid || pend_ready`.
- R8: An access with `acc_rsvd`=1 sets bit 7 when `msr_mode`=0. When `msr_mode`=1 it does not set bit 7; instead `msr_fault` pulses high in the next cycle.
- R9: An access with `acc_write`=1 to `acc_addr` equal to `STATUS_OFFSET` copies the latch into `status_rd` in the next cycle and clears the latch. Faults from that same cycle stay in the latch. Nothing else changes `status_rd`, and bits 31 to 8 always read 0.
- R10: `err_irq` is high for exactly the cycle after a fault whose flag was clear in the latch. It stays low for a repeat of a flag already latched.
- R11: Faults that occur in the same cycle are all latched together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| msr_mode | input | 1 | 1 = model-specific register access mode, 0 = memory-mapped mode |
| cfg_lowpri_ok | input | 1 | Controller supports sending lowest-priority messages |
| feat_bus_en | input | 1 | Enables bus checksum/accept flags (bits 0-3) |
| feat_redir_en | input | 1 | Enables the redirectable-send flag (bit 4) |
| snd_valid | input | 1 | Send request present |
| snd_ready | output | 1 | Always high |
| snd_vector | input | VEC_W | Send vector |
| snd_lowpri | input | 1 | Send uses lowest-priority delivery |
| snd_self | input | 1 | 1 = self-interrupt register, 0 = command register |
| rx_valid | input | 1 | Received/local interrupt present |
| rx_ready | output | 1 | Receive accepted this cycle |
| rx_vector | input | VEC_W | Received vector |
| acc_valid | input | 1 | Register access present |
| acc_write | input | 1 | Access is a write |
| acc_addr | input | ADDR_W | Register offset |
| acc_rsvd | input | 1 | Offset is reserved |
| bus_snd_cksum | input | 1 | Send checksum failure strobe |
| bus_rcv_cksum | input | 1 | Receive checksum failure strobe |
| bus_snd_noacc | input | 1 | Sent message accepted by nobody |
| bus_rcv_noacc | input | 1 | Received message accepted by nobody |
| status_rd | output | REG_W | Visible error status register |
| pend_valid | output | 1 | Pending-request set enable |
| pend_ready | input | 1 | Downstream takes the pending request |
| pend_vector | output | VEC_W | Vector to set pending |
| err_irq | output | 1 | Error interrupt pulse |
| msr_fault | output | 1 | Reserved access in model-specific mode |

## Verification
The assertions check several properties on every cycle. The reserved upper bits of the status value stay zero. No illegal vector ever reaches the pending stage. A stalled pending request keeps its vector. The receive ready follows the stage occupancy. The visible register moves only after a status write. The fault pulse always traces back to a reserved model-specific access. The precedence rules need the bench's scenarios to show them: lowest-priority suppression of the illegal-vector flag, gating by the feature enables, and self sends ignored in memory-mapped mode. So do the latch-then-copy sequence around status writes, the pulse/no-pulse behaviour of the error interrupt, and simultaneous faults. All of these are followed by the cycle-level reference model.

// File: rtl/irq_err_pkg.sv
package irq_err_pkg;
  localparam int ERR_BITS = 8;

  typedef enum int {
    EB_SND_CKSUM = 0,
    EB_RCV_CKSUM = 1,
    EB_SND_NOACC = 2,
    EB_RCV_NOACC = 3,
    EB_REDIR     = 4,
    EB_SND_ILL   = 5,
    EB_RCV_ILL   = 6,
    EB_REG_ADDR  = 7
  } err_bit_e;

  typedef logic [ERR_BITS-1:0] err_vec_t;
endpackage

// File: rtl/ies_detect.sv
module ies_detect
  import irq_err_pkg::*;
#(
  parameter int VEC_W = 8,
  parameter int LIMIT = 16
) (
  input  logic             msr_mode,
  input  logic             cfg_lowpri_ok,
  input  logic             feat_bus_en,
  input  logic             feat_redir_en,
  input  logic             snd_valid,
  input  logic [VEC_W-1:0] snd_vector,
  input  logic             snd_lowpri,
  input  logic             snd_self,
  input  logic             rx_fire,
  input  logic [VEC_W-1:0] rx_vector,
  input  logic             acc_valid,
  input  logic             acc_rsvd,
  input  logic [3:0]       bus_strb,
  output err_vec_t         ev,
  output logic             fault_hit
);
  localparam logic [VEC_W-1:0] LIM_V = VEC_W'(LIMIT);

  logic snd_live;
  logic snd_unsup;

  // a self send only exists in model-specific mode
  assign snd_live  = snd_valid && (!snd_self || msr_mode);
  assign snd_unsup = snd_lowpri && !cfg_lowpri_ok;

  for (genvar i = 0; i < 4; i++) begin : g_bus
    assign ev[i] = feat_bus_en && bus_strb[i];
  end

  assign ev[EB_REDIR]    = snd_live && snd_unsup && feat_redir_en;
  assign ev[EB_SND_ILL]  = snd_live && !snd_unsup && (snd_vector < LIM_V);
  assign ev[EB_RCV_ILL]  = rx_fire && (rx_vector < LIM_V);
  assign ev[EB_REG_ADDR] = acc_valid && acc_rsvd && !msr_mode;
  assign fault_hit       = acc_valid && acc_rsvd && msr_mode;
endmodule

// File: rtl/ies_sticky.sv
module ies_sticky
  import irq_err_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  err_vec_t ev,
  input  logic     copy,
  output err_vec_t vis,
  output logic     irq
);
  err_vec_t lat_q;
  err_vec_t vis_q;
  err_vec_t fresh;
  logic     irq_q;

  assign fresh = ev & ~lat_q;

  for (genvar b = 0; b < ERR_BITS; b++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        lat_q[b] <= 1'b0;
        vis_q[b] <= 1'b0;
      end else if (copy) begin
        vis_q[b] <= lat_q[b];
        lat_q[b] <= ev[b];
      end else begin
        lat_q[b] <= lat_q[b] | ev[b];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= |fresh;
  end

  assign vis = vis_q;
  assign irq = irq_q;
endmodule

// File: rtl/ies_pend.sv
module ies_pend #(
  parameter int VEC_W = 8,
  parameter int LIMIT = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_valid,
  output logic             rx_ready,
  input  logic [VEC_W-1:0] rx_vector,
  output logic             rx_fire,
  output logic             pend_valid,
  input  logic             pend_ready,
  output logic [VEC_W-1:0] pend_vector
);
  localparam logic [VEC_W-1:0] LIM_V = VEC_W'(LIMIT);

  logic             pv_q;
  logic [VEC_W-1:0] pvec_q;
  logic             take;

  assign rx_ready = !pv_q || pend_ready;
  assign rx_fire  = rx_valid && rx_ready;
  assign take     = rx_fire && (rx_vector >= LIM_V);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pv_q   <= 1'b0;
      pvec_q <= '0;
    end else if (take) begin
      pv_q   <= 1'b1;
      pvec_q <= rx_vector;
    end else if (pend_ready) begin
      pv_q   <= 1'b0;
    end
  end

  assign pend_valid  = pv_q;
  assign pend_vector = pvec_q;
endmodule

// File: rtl/irq_err_status.sv
module irq_err_status
  import irq_err_pkg::*;
#(
  parameter int VEC_W         = 8,
  parameter int LIMIT         = 16,
  parameter int ADDR_W        = 12,
  parameter int REG_W         = 32,
  parameter int STATUS_OFFSET = 'h280
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              msr_mode,
  input  logic              cfg_lowpri_ok,
  input  logic              feat_bus_en,
  input  logic              feat_redir_en,
  input  logic              snd_valid,
  output logic              snd_ready,
  input  logic [VEC_W-1:0]  snd_vector,
  input  logic              snd_lowpri,
  input  logic              snd_self,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [VEC_W-1:0]  rx_vector,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              acc_rsvd,
  input  logic              bus_snd_cksum,
  input  logic              bus_rcv_cksum,
  input  logic              bus_snd_noacc,
  input  logic              bus_rcv_noacc,
  output logic [REG_W-1:0]  status_rd,
  output logic              pend_valid,
  input  logic              pend_ready,
  output logic [VEC_W-1:0]  pend_vector,
  output logic              err_irq,
  output logic              msr_fault
);
  localparam int PAD = REG_W - ERR_BITS;
  localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STATUS_OFFSET);

  err_vec_t ev;
  err_vec_t vis;
  logic     rx_fire;
  logic     fault_hit;
  logic     copy;
  logic     fault_q;

  assign snd_ready = 1'b1;
  assign copy      = acc_valid && acc_write && (acc_addr == STAT_A);

  ies_pend #(.VEC_W(VEC_W), .LIMIT(LIMIT)) u_pend (
    .clk(clk), .rst_n(rst_n),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_vector(rx_vector),
    .rx_fire(rx_fire),
    .pend_valid(pend_valid), .pend_ready(pend_ready), .pend_vector(pend_vector)
  );

  ies_detect #(.VEC_W(VEC_W), .LIMIT(LIMIT)) u_det (
    .msr_mode(msr_mode), .cfg_lowpri_ok(cfg_lowpri_ok),
    .feat_bus_en(feat_bus_en), .feat_redir_en(feat_redir_en),
    .snd_valid(snd_valid), .snd_vector(snd_vector),
    .snd_lowpri(snd_lowpri), .snd_self(snd_self),
    .rx_fire(rx_fire), .rx_vector(rx_vector),
    .acc_valid(acc_valid), .acc_rsvd(acc_rsvd),
    .bus_strb({bus_rcv_noacc, bus_snd_noacc, bus_rcv_cksum, bus_snd_cksum}),
    .ev(ev), .fault_hit(fault_hit)
  );

  ies_sticky u_stk (
    .clk(clk), .rst_n(rst_n), .ev(ev), .copy(copy),
    .vis(vis), .irq(err_irq)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) fault_q <= 1'b0;
    else        fault_q <= fault_hit;
  end

  assign msr_fault = fault_q;
  assign status_rd = {{PAD{1'b0}}, vis};
endmodule

// File: rtl/ies_checker.sv
module ies_checker #(
  parameter int VEC_W         = 8,
  parameter int LIMIT         = 16,
  parameter int ADDR_W        = 12,
  parameter int REG_W         = 32,
  parameter int STATUS_OFFSET = 'h280
) (
  input logic              clk,
  input logic              rst_n,
  input logic              msr_mode,
  input logic              acc_valid,
  input logic              acc_write,
  input logic [ADDR_W-1:0] acc_addr,
  input logic              acc_rsvd,
  input logic              rx_ready,
  input logic [REG_W-1:0]  status_rd,
  input logic              pend_valid,
  input logic              pend_ready,
  input logic [VEC_W-1:0]  pend_vector,
  input logic              msr_fault
);
  localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STATUS_OFFSET);
  localparam logic [VEC_W-1:0]  LIM_V  = VEC_W'(LIMIT);

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    status_rd[REG_W-1:8] == '0); // R9
  AST_PEND_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    pend_valid |-> pend_vector >= LIM_V); // R6
  AST_PEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_valid && !pend_ready) |=> (pend_valid && $stable(pend_vector))); // R7
  AST_RX_READY: assert property (@(posedge clk) disable iff (!rst_n)
    !pend_valid |-> rx_ready); // R7
  AST_VIS_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_valid && acc_write && acc_addr == STAT_A) |=> $stable(status_rd)); // R9
  AST_FAULT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_rsvd && msr_mode) |=> msr_fault); // R8
  AST_FAULT_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_valid && acc_rsvd && msr_mode) |=> !msr_fault); // R8
endmodule

bind irq_err_status ies_checker #(
  .VEC_W(VEC_W), .LIMIT(LIMIT), .ADDR_W(ADDR_W), .REG_W(REG_W),
  .STATUS_OFFSET(STATUS_OFFSET)
) u_chk (
  .clk(clk), .rst_n(rst_n), .msr_mode(msr_mode),
  .acc_valid(acc_valid), .acc_write(acc_write), .acc_addr(acc_addr),
  .acc_rsvd(acc_rsvd), .rx_ready(rx_ready), .status_rd(status_rd),
  .pend_valid(pend_valid), .pend_ready(pend_ready),
  .pend_vector(pend_vector), .msr_fault(msr_fault)
);

// File: tb/irq_err_status_test.sv
module irq_err_status_test;
  localparam int STAT = 'h280;

  logic clk = 0;
  logic rst_n = 0;
  logic msr_mode = 0, cfg_lowpri_ok = 0, feat_bus_en = 0, feat_redir_en = 0;
  logic snd_valid = 0, snd_lowpri = 0, snd_self = 0;
  logic [7:0] snd_vector = 0;
  logic rx_valid = 0;
  logic [7:0] rx_vector = 0;
  logic acc_valid = 0, acc_write = 0, acc_rsvd = 0;
  logic [11:0] acc_addr = 0;
  logic bus_snd_cksum = 0, bus_rcv_cksum = 0, bus_snd_noacc = 0, bus_rcv_noacc = 0;
  logic pend_ready = 1;
  logic snd_ready, rx_ready, pend_valid, err_irq, msr_fault;
  logic [31:0] status_rd;
  logic [7:0] pend_vector;

  always #5 clk = ~clk;

  irq_err_status uut (.*);

  int checks = 0, fails = 0;
  string tag = "R1";

  int m_lat = 0, m_vis = 0, m_pvec = 0;
  bit m_irq = 0, m_fault = 0, m_pv = 0;

  always @(posedge clk) begin
    int ev;
    bit fire;
    if (!rst_n) begin
      m_lat = 0; m_vis = 0; m_irq = 0; m_fault = 0; m_pv = 0; m_pvec = 0;
    end else begin
      ev = 0;
      fire = rx_valid && (!m_pv || pend_ready);
      if (feat_bus_en) begin
        if (bus_snd_cksum) ev += 1;
        if (bus_rcv_cksum) ev += 2;
        if (bus_snd_noacc) ev += 4;
        if (bus_rcv_noacc) ev += 8;
      end
      if (snd_valid && (!snd_self || msr_mode)) begin
        if (snd_lowpri && !cfg_lowpri_ok) begin
          if (feat_redir_en) ev += 16;
        end else if (snd_vector < 16) ev += 32;
      end
      if (fire && rx_vector < 16) ev += 64;
      if (acc_valid && acc_rsvd && !msr_mode) ev += 128;
      m_irq = (ev & ~m_lat) != 0;
      m_fault = acc_valid && acc_rsvd && msr_mode;
      if (acc_valid && acc_write && acc_addr == STAT) begin
        m_vis = m_lat; m_lat = ev;
      end else m_lat = m_lat | ev;
      if (fire && rx_vector >= 16) begin m_pv = 1; m_pvec = rx_vector; end
      else if (pend_ready) m_pv = 0;
    end
  end

  task automatic chk(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #2;
    chk("status_rd", status_rd, m_vis);
    chk("pend_valid", pend_valid, m_pv);
    if (m_pv) chk("pend_vector", pend_vector, m_pvec);
    chk("err_irq", err_irq, m_irq);
    chk("msr_fault", msr_fault, m_fault);
    chk("rx_ready", rx_ready, (!m_pv || pend_ready));
    chk("snd_ready", snd_ready, 1);
  endtask

  task automatic quiet();
    snd_valid = 0; snd_lowpri = 0; snd_self = 0; rx_valid = 0;
    acc_valid = 0; acc_write = 0; acc_rsvd = 0; acc_addr = 0;
    bus_snd_cksum = 0; bus_rcv_cksum = 0; bus_snd_noacc = 0; bus_rcv_noacc = 0;
  endtask

  task automatic commit(int exp_vis);
    quiet();
    acc_valid = 1; acc_write = 1; acc_addr = 12'(STAT);
    tick(); quiet(); tick();
    chk("visible after write", status_rd, exp_vis);
  endtask

  task automatic send(logic [7:0] v, logic lp, logic self_src);
    quiet(); snd_valid = 1; snd_vector = v; snd_lowpri = lp; snd_self = self_src;
    tick(); quiet();
  endtask

  initial begin
    #(200000 * 10);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    tag = "R1";
    chk("reset status", status_rd, 0);
    chk("reset pend", pend_valid, 0);
    chk("reset irq", err_irq, 0);
    chk("reset fault", msr_fault, 0);
    rst_n = 1;
    tick();

    tag = "R2 R11";
    feat_bus_en = 1;
    bus_snd_cksum = 1; bus_rcv_cksum = 1; bus_snd_noacc = 1; bus_rcv_noacc = 1;
    tick(); quiet(); tick();
    commit(8'h0F);
    tag = "R2";
    feat_bus_en = 0; bus_rcv_noacc = 1; bus_snd_cksum = 1;
    tick(); quiet();
    commit(0);
    feat_bus_en = 1; bus_snd_noacc = 1; tick(); quiet();
    commit(8'h04);

    tag = "R3";
    send(8'd5, 0, 0); commit(8'h20);
    send(8'd3, 0, 1); commit(0);
    msr_mode = 1;
    send(8'd3, 0, 1); commit(8'h20);
    send(8'd5, 0, 0); commit(8'h20);
    send(8'h40, 0, 0); commit(0);
    msr_mode = 0;

    tag = "R4";
    feat_redir_en = 1; cfg_lowpri_ok = 0;
    send(8'h30, 1, 0); commit(8'h10);
    feat_redir_en = 0;
    send(8'h30, 1, 0); commit(0);
    tag = "R5";
    feat_redir_en = 1;
    send(8'd2, 1, 0); commit(8'h10);
    feat_redir_en = 0;
    send(8'd2, 1, 0); commit(0);
    cfg_lowpri_ok = 1;
    send(8'd2, 1, 0); commit(8'h20);

    tag = "R7";
    pend_ready = 0;
    rx_valid = 1; rx_vector = 8'h21; tick();
    chk("pend vector", pend_vector, 8'h21);
    rx_vector = 8'h22; tick(); tick();
    chk("held vector", pend_vector, 8'h21);
    pend_ready = 1; tick();
    chk("next vector", pend_vector, 8'h22);
    quiet(); tick(); tick();
    chk("stage empty", pend_valid, 0);
    tag = "R6";
    rx_valid = 1; rx_vector = 8'd7; tick(); quiet(); tick();
    chk("dropped", pend_valid, 0);
    rx_valid = 1; rx_vector = 8'd15; tick(); quiet();
    commit(8'h40);
    rx_valid = 1; rx_vector = 8'd16; tick(); quiet();
    commit(0);

    tag = "R8";
    acc_valid = 1; acc_rsvd = 1; acc_addr = 12'h3F0; tick(); quiet();
    commit(8'h80);
    msr_mode = 1;
    acc_valid = 1; acc_rsvd = 1; tick();
    chk("fault pulse", msr_fault, 1);
    quiet(); tick();
    chk("fault clear", msr_fault, 0);
    commit(0);
    msr_mode = 0;

    tag = "R10";
    cfg_lowpri_ok = 0; feat_redir_en = 1;
    send(8'h50, 1, 0);
    chk("first pulse", err_irq, 1);
    tick();
    chk("pulse ends", err_irq, 0);
    send(8'h50, 1, 0);
    chk("repeat no pulse", err_irq, 0);
    commit(8'h10);

    tag = "R9";
    acc_valid = 1; acc_write = 0; acc_addr = 12'(STAT); tick(); quiet(); tick();
    chk("read keeps", status_rd, 8'h10);
    bus_snd_cksum = 1; acc_valid = 1; acc_write = 1; acc_addr = 12'(STAT);
    tick(); quiet(); tick();
    chk("copy clears old", status_rd, 0);
    commit(8'h01);

    tag = "R11";
    cfg_lowpri_ok = 1;
    snd_valid = 1; snd_vector = 8'd1; rx_valid = 1; rx_vector = 8'd9;
    acc_valid = 1; acc_rsvd = 1; acc_addr = 12'h3F0; bus_rcv_cksum = 1;
    tick(); quiet();
    commit(8'hE2);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule